// File: doc/BRIEF.md
# Codec Control-Port Serial Master

This block drives the four-wire control port of an audio codec from a small host interface. The host offers a 16-bit command word on a valid/ready handshake. A read flag beside the word tells the block whether the codec's reply is wanted. The block shifts the word out most significant bit first. It frames the word with an active-low latch line and collects the codec's reply bits from the return line during the same frame.

A gated-clock serial master stops its clock when a frame ends. This block does not: its serial clock runs without pause, including during reset and between frames. The codec therefore always receives a further rising edge after the latch line has gone high, and it needs that edge to take in the word. The clock's half period in system cycles comes from a parameter. An elaboration-time check rejects any setting that would make the serial clock faster than the codec's limit.

For a read request, the 16 returned bits are placed on a parallel output when the frame closes, together with a one-cycle valid strobe. A write request leaves that output alone.

Top module: `codec_ctl_master`

## Requirements
- R1: The command word is sent most significant bit first. Exactly 16 rising serial-clock edges occur while the latch line is low, and the bit on the data line at the k-th such edge is bit 16-k of the word.
- R2: The serial clock period is 2*SCLK_HALF_DIV system cycles. The default half divider is the ceiling of SYS_CLK_HZ/(2*SCLK_MAX_HZ), which is 7 at 100 MHz with an 8 MHz limit, giving a period of at least 125 ns. Elaboration stops with an error if a half divider would break the limit.
- R3: The serial clock never holds a level for more than SCLK_HALF_DIV system cycles. This holds in reset, in idle and during frames.
- R4: The data line and the latch line change only on system edges where the serial clock falls.
- R5: The latch line goes low on the same falling edge that presents the first bit. It returns high on the falling edge after the 16th rising edge. At least one further rising edge, with latch high, occurs before the frame is reported complete.
- R6: cmd_ready is high only when the block is idle. It is low throughout the time the latch line is low, and it stays low until at least two rising edges with latch high have followed the frame. A word is taken when cmd_valid and cmd_ready are both high.
- R7: For a read request (cmd_read=1), the return line is sampled on the 16 rising edges with latch low, first sample to bit 15. After the frame, rd_data holds that word and rd_valid is high for exactly one system cycle.
- R8: For a write request (cmd_read=0), rd_valid stays low and rd_data keeps its previous value.
- R9: While rst is high, the latch line is high, the data line is 0, rd_data is 0 and rd_valid is 0, and the serial clock keeps toggling. cmd_ready is high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host offers a command word |
| cmd_ready | output | 1 | Block can take a command word |
| cmd_word | input | 16 | Command word to send |
| cmd_read | input | 1 | 1: capture the codec's reply, 0: plain write |
| rd_valid | output | 1 | One-cycle strobe that a reply word is ready |
| rd_data | output | 16 | Last reply word captured |
| ctl_sclk | output | 1 | Free-running serial clock to the codec |
| ctl_latch_n | output | 1 | Active-low frame/latch line |
| ctl_mosi | output | 1 | Serial data to the codec |
| ctl_miso | input | 1 | Serial data from the codec |

## Verification
The bench sends words with all bits zero, all bits one, a single high bit at each end, and alternating patterns. It pairs each with a reply word that differs from it, so that a reversed bit order, an off-by-one bit count or a mix-up between the transmit and receive paths each shows as a wrong word. Random words with random read/write flags are mixed in, and back-to-back requests are issued as soon as ready rises. These stress the gap between frames and confirm that writes never disturb the last reply. A serial slave model in the bench counts rising edges with latch low and with latch high. It measures the shortest clock period and flags any data or latch change off a falling edge.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SHIFT,
        ST_EXTRA,
        ST_GAP
    } frame_st_e;

    // Control strobes from sequencer to datapath
    typedef struct packed {
        logic load;     // capture the host word
        logic first;    // present MSB (frame start)
        logic advance;  // present next bit
        logic drop;     // return data line to 0
        logic sample;   // take one reply bit
        logic finish;   // publish reply word
    } shift_ctl_t;

    // Half-period divider giving a serial clock at or below max_hz
    function automatic int calc_half_div(longint sys_hz, longint max_hz);
        longint d;
        d = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        if (d < 1) d = 1;
        return int'(d);
    endfunction

    function automatic bit sclk_within_limit(longint sys_hz, longint max_hz, int half);
        return sys_hz <= 2 * longint'(half) * max_hz;
    endfunction

endpackage

// File: rtl/ccm_sclk_gen.sv
module ccm_sclk_gen #(
    parameter int HALF_DIV = 7
) (
    input  logic clk,
    output logic sclk,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    // Deliberately outside the reset domain: the clock never stops
    logic [CW-1:0] cnt_q  = '0;
    logic          sclk_q = 1'b0;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    // Strobes name the edge that happens at the coming system edge
    assign rise_now = wrap & ~sclk_q;
    assign fall_now = wrap &  sclk_q;
    assign sclk     = sclk_q;

endmodule

// File: rtl/ccm_frame_ctl.sv
module ccm_frame_ctl
    import ccm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_read,
    input  logic       rise_now,
    input  logic       fall_now,
    output logic       cmd_ready,
    output logic       latch_n,
    output shift_ctl_t ctl
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    frame_st_e      st_q;
    logic [BW-1:0]  bit_q;
    logic           rd_q;
    logic           latch_q;
    logic           last_fall;

    assign last_fall = (st_q == ST_SHIFT) && fall_now && (bit_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            bit_q   <= '0;
            rd_q    <= 1'b0;
            latch_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: if (cmd_valid) begin
                    st_q <= ST_ARM;
                    rd_q <= cmd_read;
                end
                ST_ARM: if (fall_now) begin
                    st_q    <= ST_SHIFT;
                    latch_q <= 1'b0;
                    bit_q   <= '0;
                end
                ST_SHIFT: if (fall_now) begin
                    if (bit_q == LAST_BIT) begin
                        st_q    <= ST_EXTRA;
                        latch_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BW'(1);
                    end
                end
                ST_EXTRA: if (fall_now) st_q <= ST_GAP;
                ST_GAP:   if (fall_now) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_ready   = (st_q == ST_IDLE) && !rst;
        ctl.load    = (st_q == ST_IDLE) && cmd_valid;
        ctl.first   = (st_q == ST_ARM) && fall_now;
        ctl.advance = (st_q == ST_SHIFT) && fall_now && !last_fall;
        ctl.drop    = last_fall;
        ctl.sample  = (st_q == ST_SHIFT) && rise_now;
        ctl.finish  = (st_q == ST_EXTRA) && fall_now && rd_q;
    end

    assign latch_n = latch_q;

endmodule

// File: rtl/ccm_shift_unit.sv
module ccm_shift_unit
    import ccm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              miso,
    output logic              mosi,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] rd_data_q;
    logic              mosi_q;
    logic              rd_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q       <= '0;
            rx_q       <= '0;
            rd_data_q  <= '0;
            mosi_q     <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= ctl.finish;
            if (ctl.load) begin
                tx_q <= cmd_word;
            end else if (ctl.first || ctl.advance) begin
                mosi_q <= tx_q[WORD_W-1];
                tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
            end
            if (ctl.drop)   mosi_q    <= 1'b0;
            if (ctl.sample) rx_q      <= {rx_q[WORD_W-2:0], miso};
            if (ctl.finish) rd_data_q <= rx_q;
        end
    end

    assign mosi     = mosi_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

endmodule

// File: rtl/codec_ctl_master.sv
module codec_ctl_master
    import ccm_pkg::*;
#(
    parameter longint SYS_CLK_HZ    = 100_000_000,
    parameter longint SCLK_MAX_HZ   = 8_000_000,
    parameter int     SCLK_HALF_DIV = calc_half_div(SYS_CLK_HZ, SCLK_MAX_HZ),
    parameter int     WORD_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_read,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              ctl_sclk,
    output logic              ctl_latch_n,
    output logic              ctl_mosi,
    input  logic              ctl_miso
);
    // Elaboration guard on the serial clock rate
    if (!sclk_within_limit(SYS_CLK_HZ, SCLK_MAX_HZ, SCLK_HALF_DIV)) begin : g_rate_guard
        $error("serial clock divider too small for the rate limit");
    end

    logic       rise_now;
    logic       fall_now;
    shift_ctl_t ctl;

    ccm_sclk_gen #(
        .HALF_DIV (SCLK_HALF_DIV)
    ) u_sclk (
        .clk      (clk),
        .sclk     (ctl_sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    ccm_frame_ctl #(
        .WORD_W (WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .rise_now  (rise_now),
        .fall_now  (fall_now),
        .cmd_ready (cmd_ready),
        .latch_n   (ctl_latch_n),
        .ctl       (ctl)
    );

    ccm_shift_unit #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cmd_word (cmd_word),
        .miso     (ctl_miso),
        .mosi     (ctl_mosi),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/ccm_checker.sv
module ccm_checker #(
    parameter int HALF_DIV = 7
) (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic rd_valid,
    input logic ctl_sclk,
    input logic ctl_latch_n,
    input logic ctl_mosi
);
    logic        sclk_prev = 1'b0;
    logic [31:0] run_len   = 32'd0;
    logic        rst_d     = 1'b0;

    always_ff @(posedge clk) begin
        sclk_prev <= ctl_sclk;
        run_len   <= (ctl_sclk != sclk_prev) ? 32'd1 : run_len + 32'd1;
        rst_d     <= rst;
    end

    // R3: clock never parks, even in reset
    always @(posedge clk) begin
        p_sclk_free_r3: assert (run_len <= 32'(HALF_DIV))
            else $error("serial clock held too long");
        // R9: reset holds the frame line high and no strobe
        if (rst_d) begin
            p_reset_quiet_r9: assert (ctl_latch_n && !rd_valid)
                else $error("reset state wrong");
        end
    end

    // R4: data line moves only with a falling serial edge
    p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
        !$stable(ctl_mosi) |-> $fell(ctl_sclk));

    // R4: latch line moves only with a falling serial edge
    p_latch_on_fall_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
        !$stable(ctl_latch_n) |-> $fell(ctl_sclk));

    // R6: no handshake while a frame is on the wire
    p_ready_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl_latch_n |-> !cmd_ready);

    // R7: reply strobe lasts one cycle
    p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R5: reply is reported only after the latch line is back high
    p_rdv_after_latch_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (ctl_latch_n && $past(ctl_latch_n)));

endmodule

bind codec_ctl_master ccm_checker #(
    .HALF_DIV (SCLK_HALF_DIV)
) u_ccm_checker (
    .clk         (clk),
    .rst         (rst),
    .cmd_ready   (cmd_ready),
    .rd_valid    (rd_valid),
    .ctl_sclk    (ctl_sclk),
    .ctl_latch_n (ctl_latch_n),
    .ctl_mosi    (ctl_mosi)
);

// File: tb/codec_ctl_master_tb_top.sv
module codec_ctl_master_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_read  = 1'b0;
    logic [W-1:0] cmd_word  = '0;
    logic         ctl_miso  = 1'b0;
    logic         cmd_ready, rd_valid, ctl_sclk, ctl_latch_n, ctl_mosi;
    logic [W-1:0] rd_data;

    always #5 clk = ~clk;

    codec_ctl_master dut_i (
        .clk (clk), .rst (rst),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_word (cmd_word), .cmd_read (cmd_read),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .ctl_sclk (ctl_sclk), .ctl_latch_n (ctl_latch_n),
        .ctl_mosi (ctl_mosi), .ctl_miso (ctl_miso)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Serial slave model, sampled mid-cycle
    logic [W-1:0] resp_q = '0;
    logic [W-1:0] got_q  = '0;
    logic [W-1:0] rdv_data = '0;
    int  nbits = 0, rises_hi = 0, rdv_rises = 0, rdv_cnt = 0;
    int  cyc = 0, last_rise = -1, min_per = 1000000;
    int  mosi_bad = 0, latch_bad = 0, ready_bad = 0;
    logic sclk_p = 1'b0, latch_p = 1'b1, mosi_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst && ctl_mosi !== mosi_p && !(sclk_p && !ctl_sclk)) mosi_bad++;
        if (!rst && ctl_latch_n !== latch_p && !(sclk_p && !ctl_sclk)) latch_bad++;
        if (!ctl_latch_n && cmd_ready) ready_bad++;
        if (latch_p && !ctl_latch_n) begin
            nbits = 0;
            got_q = '0;
        end
        if (!latch_p && ctl_latch_n) rises_hi = 0;
        if (!sclk_p && ctl_sclk) begin
            if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
            last_rise = cyc;
            if (!ctl_latch_n) begin
                got_q = {got_q[W-2:0], ctl_mosi};
                nbits++;
                if (nbits < W) ctl_miso = resp_q[W-1-nbits];
            end else begin
                rises_hi++;
            end
        end
        if (rd_valid) begin
            rdv_cnt++;
            rdv_data  = rd_data;
            rdv_rises = rises_hi;
        end
        if (ctl_latch_n) ctl_miso = resp_q[W-1];
        sclk_p  = ctl_sclk;
        latch_p = ctl_latch_n;
        mosi_p  = ctl_mosi;
    end

    task automatic send(input logic [W-1:0] w, input bit rd, input logic [W-1:0] resp);
        int           rdv0;
        logic [W-1:0] prev_rd;
        resp_q  = resp;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        prev_rd = rd_data;
        rdv0    = rdv_cnt;
        cmd_valid = 1'b1;
        cmd_word  = w;
        cmd_read  = rd;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_read  = 1'b0;
        cmd_word  = W'($urandom);
        while (ctl_latch_n) @(negedge clk);
        while (!ctl_latch_n) @(negedge clk);
        chk(nbits == W, "R1", "edges with latch low", nbits, W);
        chk(got_q == w, "R1", "word seen by slave", got_q, w);
        while (!cmd_ready) @(negedge clk);
        chk(rises_hi >= 2, "R6", "latch-high edges before ready", rises_hi, 2);
        if (rd) begin
            chk(rdv_cnt - rdv0 == 1, "R7", "reply strobes", rdv_cnt - rdv0, 1);
            chk(rdv_data == resp, "R7", "reply word", rdv_data, resp);
            chk(rdv_rises >= 1, "R5", "extra edge before completion", rdv_rises, 1);
        end else begin
            chk(rdv_cnt == rdv0, "R8", "reply strobes on write", rdv_cnt - rdv0, 0);
            chk(rd_data == prev_rd, "R8", "reply word kept", rd_data, prev_rd);
        end
    endtask

    initial begin
        int   tog;
        logic s;
        void'($urandom(32'h1C5));
        // R9: reset state with running clock
        tog = 0;
        s   = ctl_sclk;
        repeat (3) @(negedge clk);
        repeat (40) begin
            @(negedge clk);
            if (ctl_sclk != s) tog++;
            s = ctl_sclk;
        end
        chk(tog >= 4, "R9", "clock toggles in reset", tog, 4);
        chk(ctl_latch_n == 1'b1, "R9", "latch in reset", ctl_latch_n, 1);
        chk(ctl_mosi == 1'b0, "R9", "data in reset", ctl_mosi, 0);
        chk(rd_valid == 1'b0, "R9", "strobe in reset", rd_valid, 0);
        chk(rd_data == '0, "R9", "reply in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R9", "ready after reset", cmd_ready, 1);
        // R3: clock keeps running while idle
        tog = 0;
        s   = ctl_sclk;
        repeat (40) begin
            @(negedge clk);
            if (ctl_sclk != s) tog++;
            s = ctl_sclk;
        end
        chk(tog >= 4, "R3", "clock toggles in idle", tog, 4);

        // Directed corners
        send(16'hA5C3, 1'b1, 16'h5AF0);
        send(16'h0000, 1'b1, 16'hFFFF);
        send(16'hFFFF, 1'b1, 16'h0000);
        send(16'h8001, 1'b0, 16'h1234);
        send(16'h7FFE, 1'b1, 16'h8001);
        send(16'h5555, 1'b0, 16'hAAAA);
        // Random mix
        for (int i = 0; i < 20; i++) begin
            send(W'($urandom), 1'($urandom), W'($urandom));
        end

        chk(min_per >= 13, "R2", "shortest clock period in cycles", min_per, 13);
        chk(mosi_bad == 0, "R4", "data changes off falling edge", mosi_bad, 0);
        chk(latch_bad == 0, "R4", "latch changes off falling edge", latch_bad, 0);
        chk(ready_bad == 0, "R6", "ready while latch low", ready_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule